// File: doc/BRIEF.md
# Stepwise Pressure Feedback Regulator

This block closes the loop between a sampled airway pressure reading and the duty command sent to a blower motor's PWM stage. On every clock edge where a new pressure sample is flagged valid, it compares the sample against a working setpoint. It then moves the duty command by one fixed step: up if the pressure is low, down if it is high. A large error therefore never causes a sudden jump in airflow. Drift in the motor output and changes in supply voltage are corrected only through this pressure feedback.

The setpoint is held in half-centimetre-of-water units and moves by one unit for each Up or Down request while treatment runs. It is clamped to a parameterised window. The duty command saturates between the motor start threshold and the PWM period. When the run enable is low, the command sits at zero and nothing moves. When run is raised, the command first jumps to the start threshold so that the motor turns at once.

Top module: `pressure_step_regulator`

## Requirements
- R1: While rst_ni is low, duty_o is 0 and setpoint_o equals SP_INIT (default 10, that is 5.0 cmH2O). Immediately after reset, sat_hi_o is 0, sat_lo_o is 0 and sp_lim_o is 0.
- R2: While run_i is low, duty_o is 0 on the next edge. Pressure samples, sp_up_i and sp_dn_i have no effect.
- R3: While run_i is high, a duty_o below DUTY_MIN (default 200) is loaded with DUTY_MIN on the next edge. This start load takes precedence over any sample in that cycle.
- R4: With run_i high, duty_o at least DUTY_MIN, smp_valid_i high and smp_i below setpoint_o, duty_o rises by DUTY_STEP (default 25) on the next edge.
- R5: Under the same conditions with smp_i above setpoint_o, duty_o falls by DUTY_STEP on the next edge.
- R6: duty_o is unchanged when smp_i equals setpoint_o, or when smp_valid_i is low. No single update moves duty_o by more than DUTY_STEP.
- R7: An upward step that would exceed DUTY_PERIOD (default 1000) leaves duty_o at DUTY_PERIOD.
- R8: A downward step that would go below DUTY_MIN leaves duty_o at DUTY_MIN.
- R9: With run_i high, a cycle with sp_up_i high and sp_dn_i low raises setpoint_o by 1, but not beyond SP_MAX (default 40).
- R10: With run_i high, a cycle with sp_dn_i high and sp_up_i low lowers setpoint_o by 1, but not below SP_MIN (default 4). If both are high, setpoint_o is unchanged.
- R11: The status flags follow these rules. sat_hi_o is 1 exactly when duty_o equals DUTY_PERIOD. sat_lo_o is 1 exactly when duty_o equals DUTY_MIN. sp_lim_o is 1 exactly when setpoint_o equals SP_MIN or SP_MAX.
- R12: A sample is compared against the setpoint held before any Up or Down request in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| run_i | input | 1 | Treatment running enable |
| smp_valid_i | input | 1 | New pressure sample strobe |
| smp_i | input | SAMPLE_W | Pressure sample in half-cmH2O units |
| sp_up_i | input | 1 | Raise setpoint request pulse |
| sp_dn_i | input | 1 | Lower setpoint request pulse |
| duty_o | output | DUTY_W | Duty command to the PWM stage |
| setpoint_o | output | SAMPLE_W | Working pressure setpoint |
| sat_hi_o | output | 1 | Duty at PWM period |
| sat_lo_o | output | 1 | Duty at motor start threshold |
| sp_lim_o | output | 1 | Setpoint at a clamp limit |

## Verification
A sequence of samples is applied below, equal to and above a fixed setpoint. This separates the three comparison outcomes and shows that each correction is one step whatever the size of the error. Long runs of low or high samples drive the command into both saturation rails, which distinguishes clamping from wrap-around. Setpoint requests are sent with run off, both at once, past each clamp limit, and together with a sample strobe. These cases tell ignored requests from applied ones and show which setpoint value the comparator sees.

// File: rtl/press_reg_pkg.sv
package press_reg_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2
  } step_dir_e;
endpackage

// File: rtl/sp_tracker.sv
module sp_tracker #(
  parameter int SP_W    = 12,
  parameter int SP_MIN  = 4,
  parameter int SP_MAX  = 40,
  parameter int SP_INIT = 10
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            up_i,
  input  logic            dn_i,
  output logic [SP_W-1:0] sp_o,
  output logic            lim_o
);
  localparam logic [SP_W-1:0] LO = SP_W'(SP_MIN);
  localparam logic [SP_W-1:0] HI = SP_W'(SP_MAX);
  localparam logic [SP_W-1:0] RV = SP_W'(SP_INIT);

  logic [SP_W-1:0] sp_q, sp_d;

  always_comb begin
    sp_d = sp_q;
    if (run_i && (up_i != dn_i)) begin
      if (up_i && sp_q < HI)      sp_d = sp_q + 1'b1;
      else if (dn_i && sp_q > LO) sp_d = sp_q - 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) sp_q <= RV;
    else         sp_q <= sp_d;

  assign sp_o  = sp_q;
  assign lim_o = (sp_q == LO) || (sp_q == HI);

  // R9/R10: setpoint stays in window and moves at most one unit
  assert_sp_window_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> (sp_q >= LO && sp_q <= HI));
  assert_sp_unit_move_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((sp_q >= $past(sp_q) ? sp_q - $past(sp_q) : $past(sp_q) - sp_q) <= 1));
  assert_sp_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> $stable(sp_q));
  assert_sp_both_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (up_i && dn_i) |=> $stable(sp_q));
endmodule

// File: rtl/err_sign.sv
module err_sign
  import press_reg_pkg::*;
#(
  parameter int SAMPLE_W = 12
) (
  input  logic                valid_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic [SAMPLE_W-1:0] sp_i,
  output step_dir_e           dir_o
);
  always_comb begin
    dir_o = DIR_HOLD;
    if (valid_i) begin
      if (smp_i < sp_i)      dir_o = DIR_UP;
      else if (smp_i > sp_i) dir_o = DIR_DOWN;
    end
  end
endmodule

// File: rtl/duty_stepper.sv
module duty_stepper
  import press_reg_pkg::*;
#(
  parameter int DUTY_W      = 16,
  parameter int DUTY_MIN    = 200,
  parameter int DUTY_PERIOD = 1000,
  parameter int DUTY_STEP   = 25
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              run_i,
  input  step_dir_e         dir_i,
  output logic [DUTY_W-1:0] duty_o
);
  localparam logic [DUTY_W-1:0] MIN_D  = DUTY_W'(DUTY_MIN);
  localparam logic [DUTY_W-1:0] PER_D  = DUTY_W'(DUTY_PERIOD);
  localparam logic [DUTY_W-1:0] STEP_D = DUTY_W'(DUTY_STEP);
  localparam logic [DUTY_W-1:0] LO_KNEE = DUTY_W'(DUTY_MIN + DUTY_STEP);
  localparam logic [DUTY_W-1:0] HI_KNEE = DUTY_W'(DUTY_PERIOD - DUTY_STEP);

  logic [DUTY_W-1:0] duty_q, duty_d;

  always_comb begin
    duty_d = duty_q;
    if (!run_i)              duty_d = '0;
    else if (duty_q < MIN_D) duty_d = MIN_D;
    else begin
      unique case (dir_i)
        DIR_UP:   duty_d = (duty_q > HI_KNEE) ? PER_D : duty_q + STEP_D;
        DIR_DOWN: duty_d = (duty_q < LO_KNEE) ? MIN_D : duty_q - STEP_D;
        default:  duty_d = duty_q;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) duty_q <= '0;
    else         duty_q <= duty_d;

  assign duty_o = duty_q;

  assert_idle_zero_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !run_i |=> (duty_q == '0));
  assert_start_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && duty_q < MIN_D) |=> (duty_q == MIN_D));
  assert_one_step_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && duty_q >= MIN_D) |=>
      ((duty_q >= $past(duty_q) ? duty_q - $past(duty_q) : $past(duty_q) - duty_q) <= STEP_D));
  assert_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && duty_q >= MIN_D && dir_i == DIR_HOLD) |=> $stable(duty_q));
  assert_rails_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i) |=> (duty_q >= MIN_D && duty_q <= PER_D));
  assert_rise_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && duty_q >= MIN_D && dir_i == DIR_UP) |=> (duty_q >= $past(duty_q)));
  assert_fall_dir_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && duty_q >= MIN_D && dir_i == DIR_DOWN) |=> (duty_q <= $past(duty_q)));
endmodule

// File: rtl/pressure_step_regulator.sv
module pressure_step_regulator
  import press_reg_pkg::*;
#(
  parameter int SAMPLE_W    = 12,
  parameter int DUTY_W      = 16,
  parameter int DUTY_MIN    = 200,
  parameter int DUTY_PERIOD = 1000,
  parameter int DUTY_STEP   = 25,
  parameter int SP_MIN      = 4,
  parameter int SP_MAX      = 40,
  parameter int SP_INIT     = 10
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                run_i,
  input  logic                smp_valid_i,
  input  logic [SAMPLE_W-1:0] smp_i,
  input  logic                sp_up_i,
  input  logic                sp_dn_i,
  output logic [DUTY_W-1:0]   duty_o,
  output logic [SAMPLE_W-1:0] setpoint_o,
  output logic                sat_hi_o,
  output logic                sat_lo_o,
  output logic                sp_lim_o
);
  step_dir_e         dir;
  logic [SAMPLE_W-1:0] sp;
  logic [DUTY_W-1:0] duty;

  sp_tracker #(
    .SP_W(SAMPLE_W), .SP_MIN(SP_MIN), .SP_MAX(SP_MAX), .SP_INIT(SP_INIT)
  ) u_sp (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i),
    .up_i(sp_up_i), .dn_i(sp_dn_i), .sp_o(sp), .lim_o(sp_lim_o)
  );

  // compares against registered setpoint (R12)
  err_sign #(.SAMPLE_W(SAMPLE_W)) u_cmp (
    .valid_i(smp_valid_i), .smp_i(smp_i), .sp_i(sp), .dir_o(dir)
  );

  duty_stepper #(
    .DUTY_W(DUTY_W), .DUTY_MIN(DUTY_MIN),
    .DUTY_PERIOD(DUTY_PERIOD), .DUTY_STEP(DUTY_STEP)
  ) u_duty (
    .clk_i(clk_i), .rst_ni(rst_ni), .run_i(run_i), .dir_i(dir), .duty_o(duty)
  );

  assign duty_o     = duty;
  assign setpoint_o = sp;
  assign sat_hi_o   = (duty == DUTY_W'(DUTY_PERIOD));
  assign sat_lo_o   = (duty == DUTY_W'(DUTY_MIN));

  assert_flags_excl_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sat_hi_o && sat_lo_o));
endmodule

// File: tb/pressure_step_regulator_test.sv
module pressure_step_regulator_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        run_i = 1'b0;
  logic        smp_valid_i = 1'b0;
  logic [11:0] smp_i = '0;
  logic        sp_up_i = 1'b0;
  logic        sp_dn_i = 1'b0;
  logic [15:0] duty_o;
  logic [11:0] setpoint_o;
  logic        sat_hi_o, sat_lo_o, sp_lim_o;

  int checks = 0;
  int errors = 0;

  always #10 clk = ~clk;

  pressure_step_regulator uut (
    .clk_i(clk), .rst_ni(rst_ni), .run_i(run_i), .smp_valid_i(smp_valid_i),
    .smp_i(smp_i), .sp_up_i(sp_up_i), .sp_dn_i(sp_dn_i), .duty_o(duty_o),
    .setpoint_o(setpoint_o), .sat_hi_o(sat_hi_o), .sat_lo_o(sat_lo_o),
    .sp_lim_o(sp_lim_o)
  );

  // {sample, expected duty}; setpoint 10, duty starts at 200
  localparam logic [27:0] VECS [0:7] = '{
    {12'd5,  16'd225}, {12'd3,  16'd250}, {12'd10, 16'd250}, {12'd11, 16'd225},
    {12'd20, 16'd200}, {12'd20, 16'd200}, {12'd9,  16'd225}, {12'd10, 16'd225}
  };

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // inputs set at negedge, outputs read at the following negedge
  task automatic cyc(input logic v, input int s, input logic up, input logic dn);
    smp_valid_i = v; smp_i = 12'(s); sp_up_i = up; sp_dn_i = dn;
    @(negedge clk);
    smp_valid_i = 1'b0; sp_up_i = 1'b0; sp_dn_i = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    check("R1 duty", int'(duty_o), 0);
    check("R1 setpoint", int'(setpoint_o), 10);
    check("R1 flags", int'({sat_hi_o, sat_lo_o, sp_lim_o}), 0);
    rst_ni = 1'b1;
    @(negedge clk);

    // R2: idle ignores samples and setpoint requests
    cyc(1'b1, 0, 1'b1, 1'b0);
    check("R2 duty idle", int'(duty_o), 0);
    check("R2 setpoint idle", int'(setpoint_o), 10);

    // R3: start load wins over a low sample
    run_i = 1'b1;
    cyc(1'b1, 0, 1'b0, 1'b0);
    check("R3 start load", int'(duty_o), 200);
    check("R11 sat_lo", int'(sat_lo_o), 1);

    // R4/R5/R6/R8 via vector table
    for (int i = 0; i < 8; i++) begin
      cyc(1'b1, int'(VECS[i][27:16]), 1'b0, 1'b0);
      check($sformatf("R4/R5/R6/R8 vec %0d", i), int'(duty_o), int'(VECS[i][15:0]));
    end

    // R6: no strobe, no change
    cyc(1'b0, 0, 1'b0, 1'b0);
    check("R6 no valid", int'(duty_o), 225);

    // R7: drive up to period
    for (int i = 0; i < 40; i++) cyc(1'b1, 0, 1'b0, 1'b0);
    check("R7 upper rail", int'(duty_o), 1000);
    check("R11 sat_hi", int'(sat_hi_o), 1);
    cyc(1'b1, 20, 1'b0, 1'b0);
    check("R5 step down from rail", int'(duty_o), 975);

    // R12: sample equals old setpoint while up request
    cyc(1'b1, 10, 1'b1, 1'b0);
    check("R12 duty uses old setpoint", int'(duty_o), 975);
    check("R9 setpoint up", int'(setpoint_o), 11);

    // R10: both requests
    cyc(1'b0, 0, 1'b1, 1'b1);
    check("R10 both held", int'(setpoint_o), 11);

    // R9 clamp
    for (int i = 0; i < 35; i++) cyc(1'b0, 0, 1'b1, 1'b0);
    check("R9 clamp max", int'(setpoint_o), 40);
    check("R11 sp_lim max", int'(sp_lim_o), 1);

    // R10 clamp
    for (int i = 0; i < 40; i++) cyc(1'b0, 0, 1'b0, 1'b1);
    check("R10 clamp min", int'(setpoint_o), 4);
    check("R11 sp_lim min", int'(sp_lim_o), 1);
    cyc(1'b0, 0, 1'b1, 1'b0);
    check("R11 sp_lim clear", int'(sp_lim_o), 0);

    // R2: drop run
    run_i = 1'b0;
    cyc(1'b1, 0, 1'b0, 1'b1);
    check("R2 duty zero", int'(duty_o), 0);
    check("R2 setpoint frozen", int'(setpoint_o), 5);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule